// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Arbiter

This block holds eight single-bit ownership flags that two independent ports, left and right, share. Software on either side claims a flag by writing a 0 to it. It then reads the same flag back: a 0 means the port now owns it, and a 1 means it does not. A port gives up a flag by writing a 1 to it. A claim made while the other side holds the flag is remembered. It is granted on the clock edge at which the holder lets go, unless the claimant withdraws it first by writing a 1.

Each port has an active-low semaphore strobe, write enable, output enable and memory chip enable, a semaphore address and one data bit in each direction. A semaphore access counts only while the memory chip enable stays inactive (high). When both ports claim the same free flag on the same edge, the left port wins and the right port's claim stays pending. The block is synchronous to one clock and has an active-low synchronous reset.

Top module: `sem_arb`

## Requirements
- R1: After reset every flag is free, and both read-data outputs are 1.
- R2: A valid write (strobe low, chip enable high, write enable low) with data 0 to a flag that the other port does not hold makes the writing port its owner on that clock edge.
- R3: A valid read (strobe low, chip enable high, write enable high, output enable low) loads the port's read-data register at the clock edge. It loads 0 if that port owns the addressed flag before the edge, and 1 otherwise.
- R4: An access made while the chip enable is low (asserted), or while the strobe is high, changes no flag and no read-data register.
- R5: When both ports write 0 to the same free flag on the same edge, the left port becomes owner and the right port's claim is left pending. The two ports never own one flag at the same time.
- R6: A write of 1 by the owner frees the flag. If the other port has a claim pending on it, ownership passes to that port on the same edge.
- R7: A write of 1 by a port whose claim is pending withdraws the claim. A later release by the holder then leaves the flag free.
- R8: A write of 1 by a port that neither owns the flag nor has a claim pending on it changes nothing.
- R9: The address (0 to 7) selects one flag, and an access to one flag leaves the other seven unchanged.
- R10: While no valid read is made on a port, its read-data output keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sem_n | input | 1 | Left semaphore strobe, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ce_n | input | 1 | Left memory chip enable; semaphore accesses need it high |
| l_addr | input | 3 | Left flag select |
| l_wdata | input | 1 | Left write bit (0 claims, 1 releases) |
| l_rdata | output | 1 | Left read bit (0 means owned by left) |
| r_sem_n | input | 1 | Right semaphore strobe, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ce_n | input | 1 | Right memory chip enable; semaphore accesses need it high |
| r_addr | input | 3 | Right flag select |
| r_wdata | input | 1 | Right write bit (0 claims, 1 releases) |
| r_rdata | output | 1 | Right read bit (0 means owned by right) |

## Verification
The bound checker checks on every cycle that no flag has two owners and that a claim is never left pending on a flag that nobody holds. It also checks that a claim on a free flag is granted at once, that a release passes the flag to a pending claimant, that idle or disabled ports leave every flag untouched, and that read data holds when no read is made. The bench compares both read outputs on every clock with a behavioural model of owners and pending claims. Only its scenarios show the read-back values seen by software: a handoff seen from the waiting side, a withdrawn claim, left priority under a same-cycle collision, and how the eight flags stay independent.

// File: rtl/sem_arb.sv
module sem_arb #(
  parameter int NSEM = 8,
  localparam int AW = $clog2(NSEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sem_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic          l_ce_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wdata,
  output logic          l_rdata,
  input  logic          r_sem_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic          r_ce_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wdata,
  output logic          r_rdata
);

  logic [NSEM-1:0] own_l, own_r, pend_l, pend_r;
  logic [NSEM-1:0] own_l_d, own_r_d, pend_l_d, pend_r_d;

  wire l_sel = !l_sem_n && l_ce_n;
  wire r_sel = !r_sem_n && r_ce_n;
  wire l_wr  = l_sel && !l_we_n;
  wire r_wr  = r_sel && !r_we_n;
  wire l_rd  = l_sel && l_we_n && !l_oe_n;
  wire r_rd  = r_sel && r_we_n && !r_oe_n;

  for (genvar s = 0; s < NSEM; s++) begin : g_sem
    wire l_hit  = l_wr && (l_addr == AW'(s));
    wire r_hit  = r_wr && (r_addr == AW'(s));
    wire l_take = l_hit && !l_wdata;
    wire l_drop = l_hit && l_wdata;
    wire r_take = r_hit && !r_wdata;
    wire r_drop = r_hit && r_wdata;
    wire l_keep = own_l[s] && !l_drop;
    wire r_keep = own_r[s] && !r_drop;
    wire l_want = (pend_l[s] || l_take) && !l_drop && !own_l[s];
    wire r_want = (pend_r[s] || r_take) && !r_drop && !own_r[s];

    always_comb begin
      own_l_d[s]  = 1'b0;
      own_r_d[s]  = 1'b0;
      pend_l_d[s] = 1'b0;
      pend_r_d[s] = 1'b0;
      if (l_keep) begin
        own_l_d[s]  = 1'b1;
        pend_r_d[s] = r_want;
      end else if (r_keep) begin
        own_r_d[s]  = 1'b1;
        pend_l_d[s] = l_want;
      end else if (l_want) begin
        own_l_d[s]  = 1'b1;
        pend_r_d[s] = r_want;
      end else if (r_want) begin
        own_r_d[s]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_l   <= '0;
      own_r   <= '0;
      pend_l  <= '0;
      pend_r  <= '0;
      l_rdata <= 1'b1;
      r_rdata <= 1'b1;
    end else begin
      own_l  <= own_l_d;
      own_r  <= own_r_d;
      pend_l <= pend_l_d;
      pend_r <= pend_r_d;
      if (l_rd) l_rdata <= !own_l[l_addr];
      if (r_rd) r_rdata <= !own_r[r_addr];
    end
  end

endmodule

module sem_arb_chk #(
  parameter int NSEM = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_sem_n, l_we_n, l_oe_n, l_ce_n, l_wdata, l_rdata,
  input logic          r_sem_n, r_we_n, r_oe_n, r_ce_n, r_wdata, r_rdata,
  input logic [AW-1:0] l_addr,
  input logic [AW-1:0] r_addr,
  input logic [NSEM-1:0] own_l, own_r, pend_l, pend_r
);
  wire l_on = !l_sem_n && l_ce_n;
  wire r_on = !r_sem_n && r_ce_n;
  wire l_w0 = l_on && !l_we_n && !l_wdata;
  wire l_w1 = l_on && !l_we_n && l_wdata;
  wire r_w1 = r_on && !r_we_n && r_wdata;
  wire r_w0 = r_on && !r_we_n && !r_wdata;

  // R5
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  // R7
  no_orphan_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_l & ~own_r) == '0) && ((pend_r & ~own_l) == '0));

  // R2
  left_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_w0 && !own_r[l_addr]) |=> own_l[$past(l_addr)]);

  // R2
  right_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_w0 && !own_l[r_addr] && !(l_w0 && l_addr == r_addr)) |=> own_r[$past(r_addr)]);

  // R6
  handoff_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_w1 && own_l[l_addr] && pend_r[l_addr] && !(r_w1 && r_addr == l_addr))
      |=> own_r[$past(l_addr)]);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_on && !r_on) |=> ($stable(own_l) && $stable(own_r) && $stable(pend_l) && $stable(pend_r)));

  // R10
  l_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_on && l_we_n && !l_oe_n) |=> $stable(l_rdata));

  // R10
  r_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_on && r_we_n && !r_oe_n) |=> $stable(r_rdata));
endmodule

bind sem_arb sem_arb_chk #(.NSEM(NSEM), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_ce_n(l_ce_n),
  .l_wdata(l_wdata), .l_rdata(l_rdata),
  .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_ce_n(r_ce_n),
  .r_wdata(r_wdata), .r_rdata(r_rdata),
  .l_addr(l_addr), .r_addr(r_addr),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sem_arb_bench.sv
module sem_arb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sem_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_ce_n = 1'b1, l_wdata = 1'b1;
  logic r_sem_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_ce_n = 1'b1, r_wdata = 1'b1;
  logic [2:0] l_addr = '0, r_addr = '0;
  logic l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sem_arb u_sem_arb (
    .clk(clk), .rst_n(rst_n),
    .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_ce_n(l_ce_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_ce_n(r_ce_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // Behavioural model: owner and waiting-claim bits per flag
  bit m_ol[8], m_or[8], m_pl[8], m_pr[8];
  bit m_lrd = 1, m_rrd = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_ol[i]) begin m_ol[i] = 0; m_or[i] = 0; m_pl[i] = 0; m_pr[i] = 0; end
      m_lrd = 1; m_rrd = 1;
    end else begin
      bit lv, rv;
      lv = !l_sem_n && l_ce_n;
      rv = !r_sem_n && r_ce_n;
      if (lv && l_we_n && !l_oe_n) m_lrd = !m_ol[l_addr];
      if (rv && r_we_n && !r_oe_n) m_rrd = !m_or[r_addr];
      if (lv && !l_we_n && l_wdata) begin m_ol[l_addr] = 0; m_pl[l_addr] = 0; end
      if (rv && !r_we_n && r_wdata) begin m_or[r_addr] = 0; m_pr[r_addr] = 0; end
      if (lv && !l_we_n && !l_wdata && !m_ol[l_addr]) begin
        if (m_or[l_addr]) m_pl[l_addr] = 1; else m_ol[l_addr] = 1;
      end
      if (rv && !r_we_n && !r_wdata && !m_or[r_addr]) begin
        if (m_ol[r_addr]) m_pr[r_addr] = 1; else m_or[r_addr] = 1;
      end
      foreach (m_ol[i]) begin
        if (!m_ol[i] && !m_or[i]) begin
          if (m_pl[i]) begin m_ol[i] = 1; m_pl[i] = 0; end
          else if (m_pr[i]) begin m_or[i] = 1; m_pr[i] = 0; end
        end
      end
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R3 model left", l_rdata, m_lrd);
    check("R3 model right", r_rdata, m_rrd);
  end

  task automatic idle();
    l_sem_n = 1; l_we_n = 1; l_oe_n = 1; l_ce_n = 1; l_wdata = 1;
    r_sem_n = 1; r_we_n = 1; r_oe_n = 1; r_ce_n = 1; r_wdata = 1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic lwr(input int a, input bit d);
    l_sem_n = 0; l_we_n = 0; l_addr = 3'(a); l_wdata = d;
  endtask
  task automatic rwr(input int a, input bit d);
    r_sem_n = 0; r_we_n = 0; r_addr = 3'(a); r_wdata = d;
  endtask
  task automatic lrd(input int a);
    l_sem_n = 0; l_oe_n = 0; l_addr = 3'(a);
  endtask
  task automatic rrd(input int a);
    r_sem_n = 0; r_oe_n = 0; r_addr = 3'(a);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 left rdata after reset", l_rdata, 1'b1);
    check("R1 right rdata after reset", r_rdata, 1'b1);
    for (int a = 0; a < 8; a++) begin
      lrd(a); rrd(a); step();
      check("R1 left flag free", l_rdata, 1'b1);
      check("R1 right flag free", r_rdata, 1'b1);
    end

    // R2 acquire by left on flag 2
    lwr(2, 0); step();
    lrd(2); rrd(2); step();
    check("R2 left owns 2", l_rdata, 1'b0);
    check("R3 right sees 1 on 2", r_rdata, 1'b1);

    // R10 no read: rdata holds
    l_sem_n = 0; l_addr = 3'd0; step();
    check("R10 left holds without read", l_rdata, 1'b0);

    // R6 right waits, left releases, right takes over
    rwr(2, 0); step();
    rrd(2); step();
    check("R6 right waiting not owner", r_rdata, 1'b1);
    lwr(2, 1); step();
    rrd(2); lrd(2); step();
    check("R6 right owns after handoff", r_rdata, 1'b0);
    check("R6 left released", l_rdata, 1'b1);

    // R7 left claims 2, withdraws, right releases -> flag free
    lwr(2, 0); step();
    lwr(2, 1); step();
    rwr(2, 1); step();
    lrd(2); rrd(2); step();
    check("R7 left withdrawn not owner", l_rdata, 1'b1);
    check("R7 right released", r_rdata, 1'b1);
    rwr(2, 0); step();
    rrd(2); step();
    check("R7 flag free for right", r_rdata, 1'b0);

    // R5 same-cycle collision on flag 5
    lwr(5, 0); rwr(5, 0); step();
    lrd(5); rrd(5); step();
    check("R5 left wins collision", l_rdata, 1'b0);
    check("R5 right loses collision", r_rdata, 1'b1);
    lwr(5, 1); step();
    rrd(5); step();
    check("R5 right pending granted", r_rdata, 1'b0);

    // R9 independence: right takes 4 while holding 5
    rwr(4, 0); step();
    rrd(4); lrd(4); step();
    check("R9 right owns 4", r_rdata, 1'b0);
    check("R9 left not owner of 4", l_rdata, 1'b1);
    rrd(5); step();
    check("R9 right still owns 5", r_rdata, 1'b0);

    // R4 chip enable asserted: write and read ignored
    lwr(6, 0); l_ce_n = 0; step();
    lrd(6); step();
    check("R4 write with ce low ignored", l_rdata, 1'b1);
    lrd(5); step();
    lrd(6); l_ce_n = 0; step();
    check("R4 read with ce low ignored", l_rdata, 1'b1);
    rwr(6, 0); r_sem_n = 1; step();
    rrd(6); step();
    check("R4 strobe high ignored", r_rdata, 1'b1);

    // R8 stray release has no effect
    rwr(7, 1); step();
    lwr(7, 0); step();
    lrd(7); rrd(7); step();
    check("R8 left gets 7", l_rdata, 1'b0);
    check("R8 right not owner of 7", r_rdata, 1'b1);
    rwr(2, 1); step();
    rrd(7); lrd(7); step();
    check("R8 left keeps 7", l_rdata, 1'b0);

    repeat (2) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule